// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block produces the serial bit clock and the left/right frame clock of an audio serial port from the master audio clock, which is also the block's own clock. The division from master clock to frame rate is picked from two families, a binary family (512 down to 32 master clocks per frame) and a triple family (384 down to 48), using a small multiplier code and a family select. Each frame carries either 32 or 48 bit clocks. Besides the two clock levels, the block emits single-cycle strobes for bit-clock rising and falling edges and for the start of each frame, so that a serializer in the master clock domain can act on them without edge detection of its own.

In slave mode the generator stops dividing. It passes externally supplied bit and frame clocks through a synchronizer and presents them on the same outputs with the same strobes, so the rest of the port sees one timing interface either way. All clocks run only while the run input is high and the halt input is low; otherwise they fall to idle low with every counter cleared.

Top module: `audclk_gen`

## Requirements
- R1: With `tri_base` = 0, `mult_code` values 0, 1, 2, 3, 4 select 512, 256, 128, 64 and 32 master clocks per frame; with `tri_base` = 1, values 0, 1, 2, 3 select 384, 192, 96 and 48. Any other code gives a ratio below one bit clock per two master clocks and is an invalid setting.
- R2: With `wide_frame` = 0 a frame holds 32 bit-clock periods; with `wide_frame` = 1 it holds 48.
- R3: In master mode the bit-clock half period is H = ratio / (2 x bits per frame) master clocks. After run is raised with halt low, `bclk` first reads high H cycles later (the H-th rising clock edge), and rises again every 2H cycles.
- R4: In master mode, when the ratio is not a whole non-zero multiple of 2 x bits per frame, `cfg_err` is high (combinationally from the settings) and `bclk` and `fclk` stay low from the next cycle on.
- R5: In master mode `fclk` is low during the first half of each frame and high during the second half (bits/2 bit periods each, so bits x H cycles high); it changes only in a cycle in which `bclk` falls.
- R6: `frame_start` is a one-cycle pulse in the cycle `fclk` falls; in master mode it coincides with `bclk_fall` and the first one appears 2 x bits x H cycles after run is raised, the next 2 x bits x H cycles later.
- R7: `bclk_rise` and `bclk_fall` are one-cycle pulses, high in the first cycle `bclk` shows its new level; they are never high together.
- R8: Clocks run only while `run` = 1 and `halt` = 0. One cycle after either condition fails, all five timing outputs are low, and a restart begins again from cleared counters (first rise H cycles later).
- R9: With `slave` = 1, `bclk` and `fclk` equal `ext_bclk` and `ext_fclk` delayed by SYNC_STAGES + 1 clock edges (3 by default); the strobes mark the edges of those delayed copies, `frame_start` marking a falling `fclk`; `cfg_err` is 0 whatever the divider settings.
- R10: In slave mode with `run` = 0 or `halt` = 1, the outputs stay low while the external clocks toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master audio clock, block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables clock generation or forwarding |
| halt | input | 1 | Forces clocks idle when high |
| slave | input | 1 | 1: forward external clocks, 0: generate |
| mult_code | input | CODE_W | Divider multiplier code |
| tri_base | input | 1 | Divider family: 0 binary, 1 triple |
| wide_frame | input | 1 | 0: 32 bits per frame, 1: 48 |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_fclk | input | 1 | External frame clock (slave mode) |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame (left/right) clock |
| bclk_rise | output | 1 | Bit-clock rising-edge strobe |
| bclk_fall | output | 1 | Bit-clock falling-edge strobe |
| frame_start | output | 1 | Frame-start strobe |
| cfg_err | output | 1 | Invalid divider combination in master mode |

## Verification
The bit-clock falling edge and the end of a frame land in the same master cycle, so `bclk_fall`, the fall of `fclk` and `frame_start` must all appear together. Every master-mode run lets at least two frames complete under a randomly drawn divider setting, and the bench records whether each `frame_start` arrives with `bclk_fall` high and at the predicted cycle index. The same coincidence is judged in slave mode by driving an external frame clock whose falls line up with external bit-clock falls and comparing the strobes against delayed copies of the stimulus.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

   // Bundle of registered timing outputs shared by both clock sources.
   typedef struct packed {
      logic bclk;
      logic fclk;
      logic rise;
      logic fall;
      logic frame;
   } audclk_out_t;

   localparam audclk_out_t AUDCLK_IDLE = '0;

endpackage

// File: rtl/audclk_ratio_dec.sv
module audclk_ratio_dec #(
   parameter int unsigned CODE_W      = 3,
   parameter int unsigned BIN_LOG2    = 9,
   parameter int unsigned TRI_MANT    = 3,
   parameter int unsigned TRI_LOG2    = 7,
   parameter int unsigned NARROW_BITS = 32,
   parameter int unsigned WIDE_BITS   = 48,
   parameter int unsigned RATIO_W     = BIN_LOG2 + 2
) (
   input  logic [CODE_W-1:0]  mult_code,
   input  logic               tri_base,
   input  logic               wide_frame,
   output logic [RATIO_W-1:0] half_period,
   output logic               invalid
);

   // Elaboration-time parameter checks
   if (TRI_MANT < 1 || TRI_MANT > 3) begin : g_bad_mant
      $error("audclk_ratio_dec: TRI_MANT must be 1..3");
   end
   if ((NARROW_BITS % 2) != 0 || (WIDE_BITS % 2) != 0) begin : g_bad_bits
      $error("audclk_ratio_dec: bits per frame must be even");
   end
   if (TRI_LOG2 + 2 > RATIO_W) begin : g_bad_width
      $error("audclk_ratio_dec: RATIO_W too narrow for triple family");
   end

   logic [RATIO_W-1:0] ratio;
   logic [RATIO_W-1:0] quot [2];
   logic [RATIO_W-1:0] rem  [2];

   // Master clocks per frame from family and code
   always_comb begin
      ratio = '0;
      if (!tri_base) begin
         if (32'(mult_code) <= BIN_LOG2)
            ratio = RATIO_W'(1) << (BIN_LOG2 - 32'(mult_code));
      end else begin
         if (32'(mult_code) <= TRI_LOG2)
            ratio = RATIO_W'(TRI_MANT) << (TRI_LOG2 - 32'(mult_code));
      end
   end

   // One constant divider per frame width; power-of-two divisors use shifts
   for (genvar g = 0; g < 2; g++) begin : g_den
      localparam int unsigned DEN = (g == 0) ? 2 * NARROW_BITS : 2 * WIDE_BITS;
      if ((DEN & (DEN - 1)) == 0) begin : g_pow2
         assign quot[g] = ratio >> $clog2(DEN);
         assign rem[g]  = ratio & RATIO_W'(DEN - 1);
      end else begin : g_generic
         assign quot[g] = ratio / RATIO_W'(DEN);
         assign rem[g]  = ratio % RATIO_W'(DEN);
      end
   end

   assign half_period = quot[wide_frame];
   assign invalid     = (quot[wide_frame] == '0) || (rem[wide_frame] != '0);

endmodule

// File: rtl/audclk_master_div.sv
module audclk_master_div
   import audclk_pkg::*;
#(
   parameter int unsigned HALF_W      = 11,
   parameter int unsigned NARROW_BITS = 32,
   parameter int unsigned WIDE_BITS   = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [HALF_W-1:0] half_period,
   input  logic              wide_frame,
   output audclk_out_t       q
);

   localparam int unsigned BITS_W = $clog2(WIDE_BITS);

   if (NARROW_BITS > WIDE_BITS) begin : g_bad_order
      $error("audclk_master_div: NARROW_BITS must not exceed WIDE_BITS");
   end

   logic [HALF_W-1:0] hcnt;
   logic [BITS_W-1:0] bcnt;
   logic              tick;
   logic              last_bit;
   logic              mid_bit;

   assign tick     = (hcnt >= half_period - HALF_W'(1));
   assign last_bit = wide_frame ? (bcnt == BITS_W'(WIDE_BITS - 1))
                                : (bcnt == BITS_W'(NARROW_BITS - 1));
   assign mid_bit  = wide_frame ? (bcnt == BITS_W'(WIDE_BITS / 2 - 1))
                                : (bcnt == BITS_W'(NARROW_BITS / 2 - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         bcnt <= '0;
         q    <= AUDCLK_IDLE;
      end else if (!en) begin
         hcnt <= '0;
         bcnt <= '0;
         q    <= AUDCLK_IDLE;
      end else begin
         q.rise  <= 1'b0;
         q.fall  <= 1'b0;
         q.frame <= 1'b0;
         if (tick) begin
            hcnt   <= '0;
            q.bclk <= ~q.bclk;
            if (!q.bclk) begin
               q.rise <= 1'b1;
            end else begin
               q.fall <= 1'b1;
               if (last_bit) begin
                  bcnt    <= '0;
                  q.fclk  <= 1'b0;
                  q.frame <= 1'b1;
               end else begin
                  bcnt <= bcnt + BITS_W'(1);
                  if (mid_bit) q.fclk <= 1'b1;
               end
            end
         end else begin
            hcnt <= hcnt + HALF_W'(1);
         end
      end
   end

   AST_MDIV_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (q == AUDCLK_IDLE)); // R8
   AST_MDIV_FCLK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && $changed(q.fclk)) |-> q.fall); // R5
   AST_MDIV_FRAME_WITH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      q.frame |-> (q.fall && !q.fclk)); // R6
   AST_MDIV_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({q.rise, q.fall})); // R7
   AST_MDIV_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      q.rise |-> q.bclk); // R7

endmodule

// File: rtl/audclk_slave_sync.sv
module audclk_slave_sync
   import audclk_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        ext_bclk,
   input  logic        ext_fclk,
   output audclk_out_t q
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("audclk_slave_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] bsync;
   logic [SYNC_STAGES-1:0] fsync;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      logic b_in, f_in;
      if (g == 0) begin : g_first
         assign b_in = ext_bclk;
         assign f_in = ext_fclk;
      end else begin : g_next
         assign b_in = bsync[g-1];
         assign f_in = fsync[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bsync[g] <= 1'b0;
            fsync[g] <= 1'b0;
         end else if (!en) begin
            bsync[g] <= 1'b0;
            fsync[g] <= 1'b0;
         end else begin
            bsync[g] <= b_in;
            fsync[g] <= f_in;
         end
      end
   end

   logic b_s, f_s;
   assign b_s = bsync[SYNC_STAGES-1];
   assign f_s = fsync[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= AUDCLK_IDLE;
      end else if (!en) begin
         q <= AUDCLK_IDLE;
      end else begin
         q.bclk  <= b_s;
         q.fclk  <= f_s;
         q.rise  <= b_s & ~q.bclk;
         q.fall  <= ~b_s & q.bclk;
         q.frame <= ~f_s & q.fclk;
      end
   end

   AST_SSYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (q == AUDCLK_IDLE)); // R10
   AST_SSYNC_FRAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      q.frame |-> (!q.fclk && $past(q.fclk))); // R9

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
   import audclk_pkg::*;
#(
   parameter int unsigned CODE_W      = 3,
   parameter int unsigned BIN_LOG2    = 9,
   parameter int unsigned TRI_MANT    = 3,
   parameter int unsigned TRI_LOG2    = 7,
   parameter int unsigned NARROW_BITS = 32,
   parameter int unsigned WIDE_BITS   = 48,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              mclk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              halt,
   input  logic              slave,
   input  logic [CODE_W-1:0] mult_code,
   input  logic              tri_base,
   input  logic              wide_frame,
   input  logic              ext_bclk,
   input  logic              ext_fclk,
   output logic              bclk,
   output logic              fclk,
   output logic              bclk_rise,
   output logic              bclk_fall,
   output logic              frame_start,
   output logic              cfg_err
);

   localparam int unsigned RATIO_W = BIN_LOG2 + 2;

   logic [RATIO_W-1:0] half_period;
   logic               invalid;
   logic               m_en;
   logic               s_en;
   audclk_out_t        m_q;
   audclk_out_t        s_q;
   audclk_out_t        merged;

   audclk_ratio_dec #(
      .CODE_W(CODE_W), .BIN_LOG2(BIN_LOG2), .TRI_MANT(TRI_MANT),
      .TRI_LOG2(TRI_LOG2), .NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS),
      .RATIO_W(RATIO_W)
   ) u_dec (
      .mult_code  (mult_code),
      .tri_base   (tri_base),
      .wide_frame (wide_frame),
      .half_period(half_period),
      .invalid    (invalid)
   );

   assign m_en    = run & ~halt & ~slave & ~invalid;
   assign s_en    = run & ~halt & slave;
   assign cfg_err = invalid & ~slave;

   audclk_master_div #(
      .HALF_W(RATIO_W), .NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)
   ) u_mdiv (
      .clk        (mclk),
      .rst_n      (rst_n),
      .en         (m_en),
      .half_period(half_period),
      .wide_frame (wide_frame),
      .q          (m_q)
   );

   audclk_slave_sync #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_ssync (
      .clk     (mclk),
      .rst_n   (rst_n),
      .en      (s_en),
      .ext_bclk(ext_bclk),
      .ext_fclk(ext_fclk),
      .q       (s_q)
   );

   // The idle source holds all-zero registers, so merging is glitch-free
   assign merged      = audclk_out_t'(m_q | s_q);
   assign bclk        = merged.bclk;
   assign fclk        = merged.fclk;
   assign bclk_rise   = merged.rise;
   assign bclk_fall   = merged.fall;
   assign frame_start = merged.frame;

   AST_ERR_HOLD_LOW: assert property (@(posedge mclk) disable iff (!rst_n)
      cfg_err |=> (!bclk && !fclk)); // R4
   AST_SOURCE_EXCL: assert property (@(posedge mclk) disable iff (!rst_n)
      !(m_q.bclk && s_q.bclk)); // R9
   AST_STOP_ALL: assert property (@(posedge mclk) disable iff (!rst_n)
      (!run || halt) |=> !(bclk || fclk || bclk_rise || bclk_fall || frame_start)); // R8

endmodule

// File: tb/audclk_gen_bench.sv
`timescale 1ns/1ps
module audclk_gen_bench;

   logic       mclk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0, halt = 1'b0, slave = 1'b0;
   logic [2:0] mult_code = 3'd0;
   logic       tri_base = 1'b0, wide_frame = 1'b0;
   logic       ext_bclk = 1'b0, ext_fclk = 1'b0;
   logic       bclk, fclk, bclk_rise, bclk_fall, frame_start, cfg_err;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 0;

   always #2 mclk = ~mclk;
   always @(posedge mclk) cyc <= cyc + 1;

   audclk_gen u_audclk_gen (
      .mclk(mclk), .rst_n(rst_n), .run(run), .halt(halt), .slave(slave),
      .mult_code(mult_code), .tri_base(tri_base), .wide_frame(wide_frame),
      .ext_bclk(ext_bclk), .ext_fclk(ext_fclk),
      .bclk(bclk), .fclk(fclk), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
      .frame_start(frame_start), .cfg_err(cfg_err)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_ratio(int code, bit tb);
      if (!tb) return (code <= 4) ? (512 >> code) : 0;
      return (code <= 3) ? (384 >> code) : 0;
   endfunction

   function automatic int exp_half(int ratio, int bits);
      if (ratio == 0 || (ratio % (2 * bits)) != 0) return 0;
      return ratio / (2 * bits);
   endfunction

   function automatic int outs_any();
      return int'(bclk | fclk | bclk_rise | bclk_fall | frame_start);
   endfunction

   task automatic run_master(int code, bit tb, bit wd);
      int r, bits, h, limit;
      int first_rise = -1, second_rise = -1, first_fall = -1;
      int fs1 = -1, fs2 = -1, high_cnt = 0, rise_cnt = 0;
      int any_bclk = 0, fs_fall_ok = 1;
      @(negedge mclk);
      run = 0; slave = 0; halt = 0;
      mult_code = 3'(code); tri_base = tb; wide_frame = wd;
      @(negedge mclk);
      @(negedge mclk);
      r = exp_ratio(code, tb);
      bits = wd ? 48 : 32;
      h = exp_half(r, bits);
      chk("R1 R4 cfg_err", int'(cfg_err), int'(h == 0));
      chk("R8 idle before run", outs_any(), 0);
      run = 1;
      limit = (h == 0) ? 200 : 4 * bits * h + 4 * h + 4;
      for (int i = 1; i <= limit; i++) begin
         @(negedge mclk);
         if (bclk) any_bclk = 1;
         if (bclk_rise) begin
            if (first_rise < 0) first_rise = i;
            else if (second_rise < 0) second_rise = i;
         end
         if (bclk_fall && first_fall < 0) first_fall = i;
         if (frame_start) begin
            if (!bclk_fall) fs_fall_ok = 0;
            if (fs1 < 0) fs1 = i;
            else if (fs2 < 0) fs2 = i;
         end
         if (fs1 > 0 && fs2 < 0) begin
            if (fclk) high_cnt++;
            if (bclk_rise) rise_cnt++;
         end
      end
      if (h == 0) begin
         chk("R4 clocks held low", any_bclk, 0);
      end else begin
         chk("R1 R3 first rise", first_rise, h);
         chk("R3 rise period", second_rise - first_rise, 2 * h);
         chk("R7 first fall", first_fall, 2 * h);
         chk("R6 first frame start", fs1, 2 * bits * h);
         chk("R6 frame period", fs2 - fs1, 2 * bits * h);
         chk("R5 fclk high cycles", high_cnt, bits * h);
         chk("R2 bits per frame", rise_cnt, bits);
         chk("R6 frame with fall", fs_fall_ok, 1);
      end
      run = 0;
      @(negedge mclk);
      chk("R8 stop to idle", outs_any(), 0);
   endtask

   task automatic stop_restart();
      int first_rise = -1;
      @(negedge mclk);
      slave = 0; halt = 0; mult_code = 3'd0; tri_base = 0; wide_frame = 0;
      run = 1;
      repeat (37) @(negedge mclk);
      run = 0;
      @(negedge mclk);
      chk("R8 stop mid run", outs_any(), 0);
      repeat (5) @(negedge mclk);
      run = 1;
      for (int i = 1; i <= 20; i++) begin
         @(negedge mclk);
         if (bclk_rise && first_rise < 0) first_rise = i;
      end
      chk("R8 restart from cleared", first_rise, 8);
      halt = 1;
      @(negedge mclk);
      chk("R8 halt stops", outs_any(), 0);
      begin
         int seen = 0;
         repeat (60) begin
            @(negedge mclk);
            seen |= outs_any();
         end
         chk("R8 halt holds idle", seen, 0);
      end
      halt = 0; run = 0;
      @(negedge mclk);
   endtask

   task automatic slave_test();
      bit hb [200];
      bit hf [200];
      int bad_b = 0, bad_f = 0, bad_r = 0, bad_fs = 0, seen = 0;
      int bp, fp;
      bp = 2 + int'($urandom % 3);
      fp = bp * 2 * (4 + int'($urandom % 4));
      @(negedge mclk);
      run = 0; halt = 0; slave = 1; mult_code = 3'd7; tri_base = 1; wide_frame = 1;
      ext_bclk = 0; ext_fclk = 0;
      @(negedge mclk);
      run = 1;
      @(negedge mclk);
      chk("R9 cfg_err off in slave", int'(cfg_err), 0);
      for (int j = 0; j < 200; j++) begin
         if (j > 0) @(negedge mclk);
         if (j >= 4) begin
            if (bclk != hb[j-3]) bad_b++;
            if (fclk != hf[j-3]) bad_f++;
            if (bclk_rise != (!hb[j-4] && hb[j-3])) bad_r++;
            if (frame_start != (hf[j-4] && !hf[j-3])) bad_fs++;
         end
         hb[j] = ((j / bp) % 2) == 1;
         hf[j] = ((j / fp) % 2) == 1;
         ext_bclk = hb[j];
         ext_fclk = hf[j];
      end
      chk("R9 bclk follows external", bad_b, 0);
      chk("R9 fclk follows external", bad_f, 0);
      chk("R9 rise strobe", bad_r, 0);
      chk("R9 frame start on fclk fall", bad_fs, 0);
      run = 0;
      for (int j = 0; j < 40; j++) begin
         @(negedge mclk);
         ext_bclk = ((j / 2) % 2) == 1;
         ext_fclk = ((j / 8) % 2) == 1;
         if (j >= 1) seen |= outs_any();
      end
      chk("R10 slave stopped by run", seen, 0);
      run = 1; halt = 1; seen = 0;
      for (int j = 0; j < 40; j++) begin
         @(negedge mclk);
         ext_bclk = ((j / 2) % 2) == 1;
         ext_fclk = ((j / 8) % 2) == 1;
         seen |= outs_any();
      end
      chk("R10 slave stopped by halt", seen, 0);
      run = 0; halt = 0; slave = 0;
      @(negedge mclk);
   endtask

   initial begin
      while (cyc < 190000 && !done) @(posedge mclk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=finish", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7281));
      repeat (3) @(negedge mclk);
      chk("R8 reset idle", outs_any(), 0);
      chk("R4 reset cfg_err", int'(cfg_err), 0);
      rst_n = 1;
      @(negedge mclk);
      chk("R8 after reset idle", outs_any(), 0);
      // directed corners across both families and frame widths
      run_master(0, 0, 0);
      run_master(3, 0, 0);
      run_master(4, 0, 0);
      run_master(5, 0, 0);
      run_master(1, 0, 1);
      run_master(0, 1, 0);
      run_master(1, 1, 0);
      run_master(2, 1, 0);
      run_master(0, 1, 1);
      run_master(2, 1, 1);
      run_master(3, 1, 1);
      stop_restart();
      slave_test();
      for (int k = 0; k < 30; k++) begin
         run_master(int'($urandom % 8), bit'($urandom % 2), bit'($urandom % 2));
      end
      slave_test();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule